// File: doc/BRIEF.md
# Remote Block-Transfer Engine with Host Byte Lanes

This engine copies a block of bytes between a local buffer memory and a host data port. Software programs a 16-bit starting byte address and a 16-bit length, each written as two 8-bit halves, along with a port-shape setting. It then writes a command that picks the direction. Every beat on the host side is a request/acknowledge handshake: the engine raises a request and a beat moves only in a cycle where the host also acknowledges.

The host port is either 8 bits or 16 bits wide. In the wide shape, a configuration bit decides whether the lower-addressed byte of each pair sits on the low or the high half of the port. Three commands exist. Host-to-buffer copy and buffer-to-host copy are the two plain directions. Packet fetch is a buffer-to-host copy whose length comes from the buffer itself: the 16-bit value stored at start+2 (low byte) and start+3 (high byte), which is the length field of a received-packet header. The length registers are ignored in that mode. When the count reaches zero a sticky done flag rises. Writing a new command while a copy is running stops it at once.

Top module: `rdma_engine`

## Requirements
- R1: After reset the request, done flag, output-enable and memory write strobe are all low.
- R2: Command value 1 (host-to-buffer) writes each host beat to consecutive buffer bytes starting at the programmed start address. The registers are select 0 = start low, 1 = start high, 2 = length low, 3 = length high, 4 = config, 5 = command.
- R3: Command value 2 (buffer-to-host) presents consecutive buffer bytes starting at the start address on the host port, with output-enable high while requesting.
- R4: A beat moves only on a clock edge where request and acknowledge are both high. While acknowledge is withheld, the memory address holds, no memory write occurs and the request stays high.
- R5: With config bit 0 clear (byte port), each beat moves one byte on host bits 7..0 with memory lane mask 01, and the address advances by one.
- R6: With config bit 0 set (word port), each beat moves two bytes and the address advances by two. With config bit 1 clear, the lower-addressed byte is on host bits 7..0; with it set, that byte is on host bits 15..8.
- R7: In word mode a final remaining byte moves as one beat with lane mask 01. On a read, the unused host half is driven to zero.
- R8: The done flag rises in the cycle after the beat that brings the count to zero, and the request is then low. A zero length completes at once with no beat.
- R9: Command value 3 (packet fetch) takes its length from buffer bytes start+2 (low) and start+3 (high), ignores the length registers, and otherwise behaves as a buffer-to-host copy.
- R10: A command write while a copy is running returns the engine to idle with the done flag low, and no further memory writes occur.
- R11: Start addresses may be odd in every mode and port shape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 8 | Register write data |
| mem_addr | output | 16 | Buffer byte address of lane 0 |
| mem_re | output | 1 | Buffer read enable |
| mem_rdata | input | 16 | Buffer read data, lane 0 = byte at mem_addr, lane 1 = next byte |
| mem_we | output | 1 | Buffer write strobe |
| mem_be | output | 2 | Buffer lane mask |
| mem_wdata | output | 16 | Buffer write data by lane |
| host_req | output | 1 | Beat request |
| host_ack | input | 1 | Beat acknowledge |
| host_din | input | 16 | Host data toward buffer |
| host_dout | output | 16 | Data toward host |
| host_oe | output | 1 | Host port driven by engine |
| dma_done | output | 1 | Sticky completion flag |

## Verification
Every cycle, the embedded properties check that memory writes happen only on an acknowledged request, that a withheld acknowledge freezes the address, that byte mode never writes the high lane, that a request never stands with a zero count, and that an abort lands in idle without completion. Lane placement under both swap settings, the zero-filled half of an odd final word, the header-supplied length and the exact memory contents after copies from odd starts can only be shown by the bench's scenarios against its own buffer model.

// File: rtl/rdma_engine.sv
module rdma_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [7:0]  cfg_wdata,
  output logic [15:0] mem_addr,
  output logic        mem_re,
  input  logic [15:0] mem_rdata,
  output logic        mem_we,
  output logic [1:0]  mem_be,
  output logic [15:0] mem_wdata,
  output logic        host_req,
  input  logic        host_ack,
  input  logic [15:0] host_din,
  output logic [15:0] host_dout,
  output logic        host_oe,
  output logic        dma_done
);
  localparam int AW = 16;
  localparam int CW = 16;
  localparam logic [2:0] SEL_SA_LO = 3'd0, SEL_SA_HI = 3'd1, SEL_LEN_LO = 3'd2,
                         SEL_LEN_HI = 3'd3, SEL_CFG = 3'd4, SEL_CMD = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_XFER} st_t;

  st_t           st_q;
  logic [AW-1:0] start_q, addr_q;
  logic [CW-1:0] len_q, rem_q;
  logic [1:0]    cfg_q;
  logic          word_q, swap_q, rd_q, done_q;

  logic          cmd_wr, busy, last_odd, fire, wide;
  logic [CW-1:0] step;
  logic [7:0]    lane0, lane1, in_lo, in_hi;

  assign cmd_wr   = cfg_we && (cfg_sel == SEL_CMD);
  assign busy     = (st_q != ST_IDLE);
  assign last_odd = word_q && (rem_q == CW'(1));
  assign wide     = word_q && !last_odd;
  assign step     = wide ? CW'(2) : CW'(1);
  assign fire     = (st_q == ST_XFER) && host_ack && !cmd_wr;

  assign host_req = (st_q == ST_XFER);
  assign host_oe  = host_req && rd_q;
  assign dma_done = done_q;

  assign mem_addr = (st_q == ST_HDR) ? addr_q + AW'(2) : addr_q;
  assign mem_re   = (st_q == ST_HDR) || host_oe;

  assign lane0 = mem_rdata[7:0];
  assign lane1 = wide ? mem_rdata[15:8] : 8'h00;

  always_comb begin
    if (!host_oe)                host_dout = 16'h0000;
    else if (!word_q)            host_dout = {8'h00, lane0};
    else if (swap_q)             host_dout = {lane0, lane1};
    else                         host_dout = {lane1, lane0};
  end

  assign in_lo     = (word_q && swap_q) ? host_din[15:8] : host_din[7:0];
  assign in_hi     = swap_q ? host_din[7:0] : host_din[15:8];
  assign mem_wdata = {in_hi, in_lo};
  assign mem_be    = wide ? 2'b11 : 2'b01;
  assign mem_we    = fire && !rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      len_q   <= '0;
      cfg_q   <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_SA_LO:  start_q[7:0]  <= cfg_wdata;
        SEL_SA_HI:  start_q[15:8] <= cfg_wdata;
        SEL_LEN_LO: len_q[7:0]    <= cfg_wdata;
        SEL_LEN_HI: len_q[15:8]   <= cfg_wdata;
        SEL_CFG:    cfg_q         <= cfg_wdata[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      word_q <= 1'b0;
      swap_q <= 1'b0;
      rd_q   <= 1'b0;
      done_q <= 1'b0;
    end else if (cmd_wr) begin
      done_q <= 1'b0;
      if (busy) begin
        st_q <= ST_IDLE;
      end else if (cfg_wdata[1:0] != 2'b00) begin
        addr_q <= start_q;
        rem_q  <= len_q;
        word_q <= cfg_q[0];
        swap_q <= cfg_q[1];
        rd_q   <= cfg_wdata[1];
        if (cfg_wdata[1:0] == 2'b11) st_q <= ST_HDR;
        else if (len_q == '0)        done_q <= 1'b1;
        else                         st_q <= ST_XFER;
      end
    end else begin
      case (st_q)
        ST_HDR: begin
          rem_q <= mem_rdata;
          if (mem_rdata == 16'h0000) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            st_q <= ST_XFER;
          end
        end
        ST_XFER: if (fire) begin
          addr_q <= addr_q + step;
          rem_q  <= rem_q - step;
          if (rem_q == step) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  AST_WE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (host_req && host_ack)); // R4
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_ack && !cmd_wr) |=> (host_req && $stable(mem_addr))); // R4
  AST_REQ_HAS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    host_req |-> (rem_q != '0)); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |-> !host_req); // R8
  AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !word_q) |-> (mem_be == 2'b01)); // R5
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> (!busy && !dma_done)); // R10
endmodule

// File: tb/rdma_engine_tb_top.sv
`timescale 1ns/1ps
module rdma_engine_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [15:0] mem_addr, mem_rdata, mem_wdata, host_dout;
  logic        mem_re, mem_we, host_req, host_oe, dma_done;
  logic [1:0]  mem_be;
  logic        host_ack = 1'b0;
  logic [15:0] host_din = '0;

  logic [7:0] mem  [256];
  logic [7:0] gold [256];
  int tests = 0, fails = 0;
  bit finished = 0;

  int unsigned g_addr, g_rem;
  bit g_word, g_swap, g_rd;

  always #10 clk = ~clk;

  rdma_engine dut_i (.*);

  assign mem_rdata = {mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]};
  always_ff @(posedge clk) if (mem_we) begin
    if (mem_be[0]) mem[mem_addr[7:0]] <= mem_wdata[7:0];
    if (mem_be[1]) mem[8'(mem_addr[7:0] + 8'd1)] <= mem_wdata[15:8];
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input bit word, input bit swap, input int n,
                                           input logic [7:0] lo, input logic [7:0] hi);
    logic [7:0] h = (n == 2) ? hi : 8'h00;
    if (!word) return {8'h00, lo};
    return swap ? {lo, h} : {h, lo};
  endfunction

  function automatic logic [15:0] make_din(input bit word, input bit swap, input int n,
                                           input logic [7:0] b0, input logic [7:0] b1,
                                           input logic [7:0] junk);
    logic [7:0] h = (n == 2) ? b1 : junk;
    if (!word) return {junk, b0};
    return swap ? {b0, h} : {h, b0};
  endfunction

  task automatic wr_reg(input logic [2:0] sel, input logic [7:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start_op(input int start, input int len, input bit word, input bit swap,
                          input logic [1:0] mode);
    wr_reg(3'd0, 8'(start));
    wr_reg(3'd1, 8'(start >> 8));
    wr_reg(3'd2, 8'(len));
    wr_reg(3'd3, 8'(len >> 8));
    wr_reg(3'd4, {6'b0, swap, word});
    g_addr = start; g_rem = len; g_word = word; g_swap = swap; g_rd = mode[1];
    if (mode == 2'b11) g_rem = {gold[8'(start + 3)], gold[8'(start + 2)]};
    wr_reg(3'd5, {6'b0, mode});
  endtask

  task automatic run_beats(input int max_beats, input string req);
    int beats = 0;
    for (int t = 0; t < 4 && !host_req; t++) @(negedge clk);
    while (g_rem > 0 && beats < max_beats) begin
      if ($urandom % 4 == 0) begin
        logic [15:0] held = mem_addr;
        host_ack = 1'b0;
        @(negedge clk);
        chk(host_req && mem_addr == held && !mem_we, "R4 stall", mem_addr, held);
      end else begin
        int n = (g_word && g_rem >= 2) ? 2 : 1;
        logic [7:0] b0 = 8'($urandom), b1 = 8'($urandom), jk = 8'($urandom);
        chk(host_req && mem_addr == 16'(g_addr), {req, " R11 addr"}, mem_addr, g_addr);
        if (g_rd) begin
          logic [15:0] e = exp_read(g_word, g_swap, n, gold[8'(g_addr)], gold[8'(g_addr + 1)]);
          chk(host_oe && host_dout == e, {req, " R3/R6/R7 read lanes"}, host_dout, e);
        end else begin
          host_din = make_din(g_word, g_swap, n, b0, b1, jk);
          gold[8'(g_addr)] = b0;
          if (n == 2) gold[8'(g_addr + 1)] = b1;
        end
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
        g_addr += n; g_rem -= n; beats++;
      end
    end
    if (g_rem == 0) chk(dma_done && !host_req, {req, " R8 done"}, dma_done, 1);
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== gold[i]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin mem[i] = 8'($urandom); gold[i] = mem[i]; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!host_req && !dma_done && !host_oe && !mem_we, "R1 reset", host_req, 0);

    start_op(10, 7, 0, 0, 2'b01); run_beats(100, "R2 R5 byte write"); cmp_mem("R2 R5 mem");
    start_op(33, 9, 1, 0, 2'b01); run_beats(100, "R6 R7 R11 word write"); cmp_mem("R7 R11 mem");
    start_op(61, 8, 1, 1, 2'b01); run_beats(100, "R6 swap write"); cmp_mem("R6 mem");
    start_op(15, 11, 1, 1, 2'b10); run_beats(100, "R3 R7 swap read");
    start_op(70, 6, 0, 1, 2'b10); run_beats(100, "R5 byte read");

    mem[122] = 8'd9; mem[123] = 8'd0; gold[122] = 8'd9; gold[123] = 8'd0;
    start_op(120, 16'h7777, 1, 0, 2'b11);
    chk(g_rem == 9, "R9 header len", g_rem, 9);
    run_beats(100, "R9 packet fetch");

    start_op(5, 0, 1, 0, 2'b10);
    chk(dma_done && !host_req, "R8 zero length", dma_done, 1);

    start_op(140, 20, 1, 0, 2'b01); run_beats(3, "R10 pre-abort");
    wr_reg(3'd5, 8'h01);
    chk(!host_req && !dma_done, "R10 abort idle", {host_req, dma_done}, 0);
    repeat (2) @(negedge clk);
    cmp_mem("R10 no extra writes");
    start_op(141, 5, 1, 1, 2'b01); run_beats(100, "R10 after abort"); cmp_mem("R10 R11 mem");

    for (int k = 0; k < 14; k++) begin
      int st = $urandom % 200;
      int ln = 1 + $urandom % 40;
      logic [1:0] md = 2'(1 + $urandom % 3);
      if (md == 2'b11) begin
        mem[8'(st + 2)] = 8'(ln); mem[8'(st + 3)] = 8'h00;
        gold[8'(st + 2)] = 8'(ln); gold[8'(st + 3)] = 8'h00;
      end
      start_op(st, ln, 1'($urandom), 1'($urandom), md);
      run_beats(200, "R2 R3 R9 random");
      cmp_mem("R2 random mem");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule